// File: doc/BRIEF.md
# Masked Frame-Field Offset Comparator

This block looks at a received frame as it streams past, one byte per accepted cycle, and checks a pool of programmable compare entries against it. Each entry selects a 16-bit window of two consecutive bytes. The window is placed at a byte offset from one of four points in the frame: the frame start, the byte after the last EtherType, the byte after the IP header, or the first byte of the TCP/UDP header. Each entry ANDs the two bytes with a per-entry mask and compares the result with a per-entry value. The results for all entries appear together once the frame has ended.

An upstream header parser supplies pulses that mark the anchor points, and this block only counts bytes from them. A downstream classifier uses the match vector. Entries are loaded through a simple indexed write port between frames. Each entry holds a 7-bit offset, a 2-bit anchor select, a 16-bit value and a 16-bit mask. The first byte of the window is compared with value/mask bits 7:0 and the second byte with bits 15:8.

Top module: `frame_field_cmp`

## Requirements
- R1: After reset `resValid` is 0 and `resMatch` is all zeros, and every entry holds offset 0, anchor 0, value 0 and mask 0.
- R2: An entry matches when (first byte AND mask[7:0]) equals value[7:0] and (second byte AND mask[15:8]) equals value[15:8]. A value bit set where the mask bit is 0 can never match.
- R3: Anchor code 0 counts the offset from the frame start. Offset 0 is the byte accepted with `inSof`.
- R4: Anchor code 1 counts from the byte after a byte flagged by `etEndPulse`. When several such pulses occur in one frame (tagged frames), the last one sets the anchor and bytes captured from an earlier one are discarded.
- R5: Anchor code 2 counts from the byte after the byte flagged by `ipEndPulse`.
- R6: Anchor code 3 counts from the byte flagged by `l4StartPulse`, which is itself offset 0.
- R7: Offsets span 0 to 127. At offset 127 the second byte of the window is anchor position 128, and the compare still uses it.
- R8: An entry's result is 0 if the frame ends before both of its bytes arrive, or if its anchor never occurs in the frame.
- R9: `resValid` is high for exactly the cycle after the `inEof` byte is accepted. `resMatch` updates in that cycle and holds until the next frame ends.
- R10: Cycles with `inValid` low are ignored. Data and marker inputs in those cycles neither advance positions nor set anchors.
- R11: A cycle with `cfgWe` high loads the fields into entry `cfgIdx`. All 32 entries are independent and take effect for frames that start afterwards.
- R12: Anchor state does not carry across frames. A marker seen in one frame leaves the entries that use that anchor unmatched in a later frame without the marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Entry write strobe |
| cfgIdx | input | 5 | Entry index to write |
| cfgOffset | input | 7 | Byte offset from the anchor |
| cfgAnchor | input | 2 | Anchor code 0..3 |
| cfgValue | input | 16 | Compare value, bits 7:0 for the first byte |
| cfgMask | input | 16 | Compare mask, bits 7:0 for the first byte |
| inValid | input | 1 | Byte accepted this cycle |
| inData | input | 8 | Frame byte |
| inSof | input | 1 | First byte of frame |
| inEof | input | 1 | Last byte of frame |
| etEndPulse | input | 1 | Byte is the last byte of an EtherType field |
| ipEndPulse | input | 1 | Byte is the last byte of the IP header |
| l4StartPulse | input | 1 | Byte is the first byte of the L4 header |
| resValid | output | 1 | Results valid strobe |
| resMatch | output | 32 | Per-entry match result |

## Verification
The bench places windows at offsets 126 and 127 of a 130-byte frame. A counter that is too narrow, or one that saturates too early, would lose the byte at position 128. Frames carry two EtherType pulses, with different data after each one, so a design that latched the first pulse would report the wrong entry. Other frames stop one byte short of a window, or carry no anchor at all, and a design that reported half-captured windows would show false matches. Idle gaps inside a frame, and a frame without an EtherType pulse that follows one with it, expose designs that count idle cycles or keep anchor state across frames.

// File: rtl/frame_field_cmp_pkg.sv
package frame_field_cmp_pkg;

  localparam int NUM_ANCHORS = 4;

  typedef enum logic [1:0] {
    ANC_FRAME = 2'd0,
    ANC_ETYPE = 2'd1,
    ANC_IPEND = 2'd2,
    ANC_L4    = 2'd3
  } anchor_e;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic                   byteStb;   // accepted in-frame byte
    logic                   frameEnd;  // accepted end-of-frame byte
    logic [NUM_ANCHORS-1:0] live;      // byte lies inside anchor region
    logic [NUM_ANCHORS-1:0] restart;   // anchor (re)starts on this byte
  } fcmpStrobe_t;

endpackage

// File: rtl/frame_field_cmp_ctrl.sv
module frame_field_cmp_ctrl
  import frame_field_cmp_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               inValid,
  input  logic                               inSof,
  input  logic                               inEof,
  input  logic                               etEndPulse,
  input  logic                               ipEndPulse,
  input  logic                               l4StartPulse,
  output fcmpStrobe_t                        stb,
  output logic [NUM_ANCHORS-1:0][POS_W-1:0]  anchorPos
);

  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic [NUM_ANCHORS-1:0]            armedQ;  // bit 0 doubles as "in frame"
  logic [NUM_ANCHORS-1:0][POS_W-1:0] cntQ;
  logic                              inFrameNow;

  assign inFrameNow = inSof | armedQ[ANC_FRAME];

  always_comb begin
    stb.byteStb  = inValid & inFrameNow;
    stb.frameEnd = inValid & inFrameNow & inEof;

    stb.restart[ANC_FRAME] = stb.byteStb & inSof;
    stb.restart[ANC_ETYPE] = stb.byteStb & etEndPulse;
    stb.restart[ANC_IPEND] = stb.byteStb & ipEndPulse;
    stb.restart[ANC_L4]    = stb.byteStb & l4StartPulse;

    stb.live[ANC_FRAME] = inFrameNow;
    stb.live[ANC_ETYPE] = armedQ[ANC_ETYPE] & ~inSof;
    stb.live[ANC_IPEND] = armedQ[ANC_IPEND] & ~inSof;
    stb.live[ANC_L4]    = inFrameNow & (l4StartPulse | (armedQ[ANC_L4] & ~inSof));

    anchorPos[ANC_FRAME] = inSof ? '0 : cntQ[ANC_FRAME];
    anchorPos[ANC_ETYPE] = cntQ[ANC_ETYPE];
    anchorPos[ANC_IPEND] = cntQ[ANC_IPEND];
    anchorPos[ANC_L4]    = l4StartPulse ? '0 : cntQ[ANC_L4];
  end

  // Anchors 0 and 3 include the marked byte; anchors 1 and 2 start after it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= '0;
      cntQ   <= '0;
    end else if (stb.byteStb) begin
      for (int a = 0; a < NUM_ANCHORS; a++) begin
        if (stb.restart[a]) begin
          armedQ[a] <= 1'b1;
          cntQ[a]   <= (a == ANC_FRAME || a == ANC_L4) ? POS_W'(1) : '0;
        end else if (inSof) begin
          armedQ[a] <= 1'b0;
        end else if (armedQ[a] && cntQ[a] != POS_MAX) begin
          cntQ[a] <= cntQ[a] + 1'b1;
        end
      end
      if (inEof) armedQ <= '0;
    end
  end

  // R12: every anchor is disarmed once a frame ends
  a_r12_disarm_at_eof: assert property (@(posedge clk) disable iff (!rstN)
    stb.frameEnd |=> (armedQ == '0));

  // R10: idle cycles leave the position state untouched
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (cntQ == $past(cntQ)) && (armedQ == $past(armedQ)));

endmodule

// File: rtl/frame_field_cmp_dp.sv
module frame_field_cmp_dp
  import frame_field_cmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int OFFSET_W    = 7,
  parameter int POS_W       = OFFSET_W + 1,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              cfgWe,
  input  logic [IDX_W-1:0]                  cfgIdx,
  input  logic [OFFSET_W-1:0]               cfgOffset,
  input  logic [1:0]                        cfgAnchor,
  input  logic [15:0]                       cfgValue,
  input  logic [15:0]                       cfgMask,
  input  logic [7:0]                        inData,
  input  fcmpStrobe_t                       stb,
  input  logic [NUM_ANCHORS-1:0][POS_W-1:0] anchorPos,
  output logic                              resValid,
  output logic [NUM_ENTRIES-1:0]            resMatch
);

  logic [OFFSET_W-1:0] offsetQ [NUM_ENTRIES];
  logic [1:0]          anchorQ [NUM_ENTRIES];
  logic [15:0]         valueQ  [NUM_ENTRIES];
  logic [15:0]         maskQ   [NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0] gotLoQ, gotHiQ;
  logic [NUM_ENTRIES-1:0] matchNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        offsetQ[e] <= '0;
        anchorQ[e] <= '0;
        valueQ[e]  <= '0;
        maskQ[e]   <= '0;
      end
    end else if (cfgWe) begin
      offsetQ[cfgIdx] <= cfgOffset;
      anchorQ[cfgIdx] <= cfgAnchor;
      valueQ[cfgIdx]  <= cfgValue;
      maskQ[cfgIdx]   <= cfgMask;
    end
  end

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    logic [7:0]       loByteQ, hiByteQ, loByteN, hiByteN;
    logic [POS_W-1:0] pos, posLo, posHi;
    logic             live, clr, hitLo, hitHi, loKeep, gotLoN, gotHiN;

    always_comb begin
      pos     = anchorPos[anchorQ[i]];
      posLo   = POS_W'(offsetQ[i]);
      posHi   = posLo + 1'b1;
      live    = stb.byteStb & stb.live[anchorQ[i]];
      clr     = stb.restart[anchorQ[i]] | stb.restart[ANC_FRAME];
      hitLo   = live & (pos == posLo);
      loKeep  = gotLoQ[i] & ~clr;
      hitHi   = live & loKeep & (pos == posHi);
      gotLoN  = loKeep | hitLo;
      gotHiN  = (gotHiQ[i] & ~clr) | hitHi;
      loByteN = hitLo ? inData : loByteQ;
      hiByteN = hitHi ? inData : hiByteQ;
      matchNext[i] = gotLoN & gotHiN &
                     ((loByteN & maskQ[i][7:0])  == valueQ[i][7:0]) &
                     ((hiByteN & maskQ[i][15:8]) == valueQ[i][15:8]);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        gotLoQ[i] <= 1'b0;
        gotHiQ[i] <= 1'b0;
        loByteQ   <= '0;
        hiByteQ   <= '0;
      end else if (stb.byteStb) begin
        gotLoQ[i] <= gotLoN;
        gotHiQ[i] <= gotHiN;
        loByteQ   <= loByteN;
        hiByteQ   <= hiByteN;
      end
    end

    // R8: the second byte is never held without the first
    a_r8_hi_after_lo: assert property (@(posedge clk) disable iff (!rstN)
      !(gotHiQ[i] && !gotLoQ[i]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resMatch <= '0;
    end else begin
      resValid <= stb.frameEnd;
      if (stb.frameEnd) resMatch <= matchNext;
    end
  end

  // R11: a write lands in the addressed entry
  a_r11_cfg_lands: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (offsetQ[$past(cfgIdx)] == $past(cfgOffset)) &&
              (maskQ[$past(cfgIdx)] == $past(cfgMask)));

endmodule

// File: rtl/frame_field_cmp.sv
module frame_field_cmp
  import frame_field_cmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int OFFSET_W    = 7,
  localparam int POS_W      = OFFSET_W + 1,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWe,
  input  logic [IDX_W-1:0]       cfgIdx,
  input  logic [OFFSET_W-1:0]    cfgOffset,
  input  logic [1:0]             cfgAnchor,
  input  logic [15:0]            cfgValue,
  input  logic [15:0]            cfgMask,
  input  logic                   inValid,
  input  logic [7:0]             inData,
  input  logic                   inSof,
  input  logic                   inEof,
  input  logic                   etEndPulse,
  input  logic                   ipEndPulse,
  input  logic                   l4StartPulse,
  output logic                   resValid,
  output logic [NUM_ENTRIES-1:0] resMatch
);

  fcmpStrobe_t                       stb;
  logic [NUM_ANCHORS-1:0][POS_W-1:0] anchorPos;

  frame_field_cmp_ctrl #(.POS_W(POS_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .inSof        (inSof),
    .inEof        (inEof),
    .etEndPulse   (etEndPulse),
    .ipEndPulse   (ipEndPulse),
    .l4StartPulse (l4StartPulse),
    .stb          (stb),
    .anchorPos    (anchorPos)
  );

  frame_field_cmp_dp #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .OFFSET_W    (OFFSET_W),
    .POS_W       (POS_W),
    .IDX_W       (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgIdx    (cfgIdx),
    .cfgOffset (cfgOffset),
    .cfgAnchor (cfgAnchor),
    .cfgValue  (cfgValue),
    .cfgMask   (cfgMask),
    .inData    (inData),
    .stb       (stb),
    .anchorPos (anchorPos),
    .resValid  (resValid),
    .resMatch  (resMatch)
  );

  // R9: results only appear right after an accepted end-of-frame byte
  a_r9_valid_after_eof: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(inValid && inEof));

endmodule

// File: tb/frame_field_cmp_tb.sv
module frame_field_cmp_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [4:0]  cfgIdx = '0;
  logic [6:0]  cfgOffset = '0;
  logic [1:0]  cfgAnchor = '0;
  logic [15:0] cfgValue = '0;
  logic [15:0] cfgMask = '0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = '0;
  logic        inSof = 1'b0, inEof = 1'b0;
  logic        etEndPulse = 1'b0, ipEndPulse = 1'b0, l4StartPulse = 1'b0;
  logic        resValid;
  logic [31:0] resMatch;

  always #10 clk = ~clk;

  frame_field_cmp u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cfgOffset(cfgOffset), .cfgAnchor(cfgAnchor), .cfgValue(cfgValue),
    .cfgMask(cfgMask), .inValid(inValid), .inData(inData), .inSof(inSof),
    .inEof(inEof), .etEndPulse(etEndPulse), .ipEndPulse(ipEndPulse),
    .l4StartPulse(l4StartPulse), .resValid(resValid), .resMatch(resMatch)
  );

  int nChecks = 0, nFails = 0;

  // Bench-side frame and entry model
  logic [7:0]  frm [256];
  int          frmLen, etA, etB, ipP, l4P;
  bit          useGaps;
  logic [6:0]  mOff [32];
  logic [1:0]  mAnc [32];
  logic [15:0] mVal [32];
  logic [15:0] mMsk [32];
  logic [31:0] lastRes;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model();
    logic [31:0] r = '0;
    for (int e = 0; e < 32; e++) begin
      int base, idx;
      case (mAnc[e])
        2'd0: base = 0;
        2'd1: base = (etB >= 0) ? etB + 1 : ((etA >= 0) ? etA + 1 : -1);
        2'd2: base = (ipP >= 0) ? ipP + 1 : -1;
        default: base = l4P;
      endcase
      idx = base + int'(mOff[e]);
      if (base >= 0 && idx + 1 < frmLen)
        r[e] = ((frm[idx] & mMsk[e][7:0]) == mVal[e][7:0]) &&
               ((frm[idx+1] & mMsk[e][15:8]) == mVal[e][15:8]);
    end
    return r;
  endfunction

  task automatic buildFrame(input int len, input int seed);
    frmLen = len; etA = -1; etB = -1; ipP = -1; l4P = -1; useGaps = 0;
    for (int i = 0; i < 256; i++) frm[i] = 8'((i * 37 + seed) & 255);
  endtask

  task automatic cfgWrite(input int idx, input int off, input int anc, input logic [15:0] val, input logic [15:0] msk);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = 5'(idx); cfgOffset = 7'(off); cfgAnchor = 2'(anc);
    cfgValue = val; cfgMask = msk;
    mOff[idx] = 7'(off); mAnc[idx] = 2'(anc); mVal[idx] = val; mMsk[idx] = msk;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic idleInputs();
    inValid = 1'b0; inData = 8'hEE; inSof = 1'b0; inEof = 1'b0;
    etEndPulse = 1'b0; ipEndPulse = 1'b0; l4StartPulse = 1'b0;
  endtask

  // Drives the frame, then checks the R9 strobe timing; returns the vector
  task automatic sendFrame(output logic [31:0] got);
    for (int i = 0; i < frmLen; i++) begin
      if (useGaps && (i % 2 == 1)) begin
        @(negedge clk);
        idleInputs();
        inSof = 1'b1; inEof = 1'b1; etEndPulse = 1'b1; l4StartPulse = 1'b1;
      end
      @(negedge clk);
      inValid = 1'b1; inData = frm[i];
      inSof = (i == 0); inEof = (i == frmLen - 1);
      etEndPulse = (i == etA) || (i == etB);
      ipEndPulse = (i == ipP);
      l4StartPulse = (i == l4P);
    end
    @(negedge clk);
    idleInputs();
    check(resValid === 1'b1, "R9 valid after eof", 32'(resValid), 32'd1);
    got = resMatch;
    @(negedge clk);
    check(resValid === 1'b0, "R9 single-cycle valid", 32'(resValid), 32'd0);
  endtask

  task automatic t_reset();
    check(resValid === 1'b0, "R1 reset valid", 32'(resValid), 32'd0);
    check(resMatch === 32'd0, "R1 reset match", resMatch, 32'd0);
    buildFrame(4, 5);
    sendFrame(lastRes);
    check(lastRes === 32'hFFFF_FFFF, "R1 default entries match all", lastRes, 32'hFFFF_FFFF);
  endtask

  task automatic t_frame_start();
    logic [31:0] got, exp;
    for (int e = 0; e < 32; e++) cfgWrite(e, 0, 0, 16'h0001, 16'h0000);
    buildFrame(130, 3);
    frm[0] = 8'h12; frm[1] = 8'h34;
    cfgWrite(0, 0, 0, 16'h3412, 16'hFFFF);
    cfgWrite(1, 126, 0, {frm[127], frm[126]}, 16'hFFFF);
    cfgWrite(2, 127, 0, {frm[128], frm[127]}, 16'hFFFF);
    cfgWrite(3, 0, 0, 16'h0112, 16'h00FF);
    cfgWrite(4, 0, 0, 16'h3002, 16'hF00F);
    cfgWrite(5, 127, 0, {frm[128] ^ 8'h01, frm[127]}, 16'hFFFF);
    sendFrame(got);
    exp = model();
    check(got[0] === 1'b1 && exp[0], "R3 offset 0 at sof byte", got, exp);
    check(got[4:3] === 2'b10, "R2 mask and value rule", 32'(got[4:3]), 32'b10);
    check(got[2:1] === 2'b11 && got[5] === 1'b0, "R7 offsets 126/127", got, exp);
    check(got === exp, "R2 full vector", got, exp);
  endtask

  task automatic t_etype();
    logic [31:0] got, exp;
    buildFrame(40, 9);
    etA = 12; etB = 16;
    frm[13] = 8'hAA; frm[14] = 8'hBB; frm[17] = 8'h11; frm[18] = 8'h22;
    cfgWrite(6, 0, 1, 16'h2211, 16'hFFFF);
    cfgWrite(7, 0, 1, 16'hBBAA, 16'hFFFF);
    cfgWrite(8, 3, 1, {frm[21], frm[20]}, 16'hFFFF);
    sendFrame(got);
    exp = model();
    check(got[8:6] === 3'b101, "R4 last EtherType anchor", 32'(got[8:6]), 32'b101);
    check(got === exp, "R4 full vector", got, exp);
  endtask

  task automatic t_ip_l4();
    logic [31:0] got, exp;
    buildFrame(60, 21);
    etA = 13; ipP = 33; l4P = 40;
    cfgWrite(9, 2, 2, {frm[37], frm[36]}, 16'hFFFF);
    cfgWrite(10, 0, 3, {frm[41], frm[40]}, 16'hFFFF);
    cfgWrite(11, 5, 3, {frm[46], frm[45]}, 16'hFFFF);
    cfgWrite(12, 0, 2, {frm[41], frm[40]} ^ 16'h8000, 16'hFFFF);
    sendFrame(got);
    exp = model();
    check(got[9] === 1'b1, "R5 IP-end anchor", 32'(got[9]), 32'd1);
    check(got[11:10] === 2'b11 && got[12] === 1'b0, "R6 L4 anchor", 32'(got[12:10]), 32'b011);
    check(got === exp, "R6 full vector", got, exp);
  endtask

  task automatic t_short();
    logic [31:0] got, exp;
    buildFrame(20, 44);
    cfgWrite(13, 19, 0, {8'h00, frm[19]}, 16'h00FF);
    cfgWrite(14, 0, 3, 16'h0000, 16'h0000);
    cfgWrite(15, 0, 2, 16'h0000, 16'h0000);
    cfgWrite(16, 18, 0, 16'h0000, 16'h0000);
    sendFrame(got);
    exp = model();
    check(got[16:13] === 4'b1000, "R8 short frame / missing anchor", 32'(got[16:13]), 32'b1000);
    check(got === exp, "R8 full vector", got, exp);
  endtask

  task automatic t_gaps();
    logic [31:0] got, exp;
    buildFrame(60, 21);
    etA = 13; ipP = 33; l4P = 40; useGaps = 1;
    sendFrame(got);
    exp = model();
    check(got === exp, "R10 idle cycles ignored", got, exp);
  endtask

  task automatic t_carry();
    logic [31:0] got, exp;
    buildFrame(40, 9);
    etA = 12; etB = 16;
    frm[17] = 8'h11; frm[18] = 8'h22;
    sendFrame(got);
    check(got[6] === 1'b1, "R12 setup frame", 32'(got[6]), 32'd1);
    buildFrame(40, 9);
    frm[17] = 8'h11; frm[18] = 8'h22;
    sendFrame(got);
    exp = model();
    check(got[8:6] === 3'b000 && got === exp, "R12 no anchor carry-over", got, exp);
  endtask

  task automatic t_hold();
    logic [31:0] got;
    buildFrame(60, 21);
    etA = 13; ipP = 33; l4P = 40;
    sendFrame(got);
    repeat (3) @(negedge clk);
    check(resMatch === got, "R9 result held", resMatch, got);
  endtask

  task automatic t_all_entries();
    logic [31:0] got, exp;
    buildFrame(120, 77);
    for (int e = 0; e < 32; e++) begin
      logic [15:0] v = {frm[e*3+1], frm[e*3]};
      cfgWrite(e, e * 3, 0, (e % 2 == 1) ? v : (v ^ 16'h0100), 16'hFFFF);
    end
    sendFrame(got);
    exp = model();
    check(got === 32'hAAAA_AAAA, "R11 all entries independent", got, 32'hAAAA_AAAA);
    check(got === exp, "R11 model vector", got, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int e = 0; e < 32; e++) begin
      mOff[e] = '0; mAnc[e] = '0; mVal[e] = '0; mMsk[e] = '0;
    end
    idleInputs();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_frame_start();
    t_etype();
    t_ip_l4();
    t_short();
    t_gaps();
    t_carry();
    t_hold();
    t_all_entries();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule